// File: doc/BRIEF.md
# Four-Tone Dual-Command Receiver Logic

This block turns four received carrier-tone presence levels into two independent command channels, A and B. One tone is the guard. One tone requests a trip on command A only, one requests a trip on command B only, and the fourth requests a trip on both commands together. Each command channel works out its own guard-present and loss-of-channel conditions. It keeps its own trip lockout and drives its own trip, guard and checkback outputs.

A channel is locked out from tripping when it leaves reset. It becomes able to trip only after its guard has been seen without a break for a set number of millisecond ticks. If the channel then sits in loss of channel (no guard and no trip tone) for a set number of ticks, it locks out again. A trip request on a locked channel raises only the checkback output. The trip and guard outputs each have a hold stretch, set per channel as a static input. The stretch works on the outputs only and never feeds back into the lockout logic. Tone detection happens upstream. The hold settings are static inputs.

Top module: `dual_cmd_tone_rx`

## Requirements
- R1: The trip request of command A is `tone_cmd_a | tone_both`, and the trip request of command B is `tone_cmd_b | tone_both`. Any mix of tones asserts the union of the commands they imply, and `ckbk_a`/`ckbk_b` follow these requests in the same cycle.
- R2: A channel's guard is present when `tone_guard` is high and that channel's own trip request is low. A trip request on one command leaves the other command's guard output and lockout unchanged.
- R3: After reset both channels are locked out. With all tones low, every output is low. A trip request then raises the checkback outputs but not the trip outputs.
- R4: The lockout clears at the clock edge carrying the GBT_TICKS-th consecutive tick at which the guard is present. A tick that sees no guard restarts the count.
- R5: The lockout sets at the clock edge carrying the TAG_TICKS-th consecutive tick in loss of channel (guard absent, no trip request). A trip request that arrives before that edge still trips.
- R6: On an unlocked channel a trip request drives the trip output high in the same cycle. On a locked channel it drives only the checkback output.
- R7: Each channel's lockout depends only on that channel's own guard and loss conditions.
- R8: When a channel's trip ends, its trip output stays high for exactly min(trip hold setting, HOLD_MAX) further ticks. A setting of 0 gives no stretch.
- R9: When a channel's guard ends, its guard output stays high for exactly min(guard hold setting, HOLD_MAX) further ticks. A setting of 0 gives no stretch.
- R10: A hold setting above HOLD_MAX behaves as HOLD_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| tone_guard | input | 1 | Guard tone present |
| tone_cmd_a | input | 1 | Command A trip tone present |
| tone_cmd_b | input | 1 | Command B trip tone present |
| tone_both | input | 1 | Combined A and B trip tone present |
| trip_hold_a | input | HOLD_W | Trip hold setting for A, in ticks |
| guard_hold_a | input | HOLD_W | Guard hold setting for A, in ticks |
| trip_hold_b | input | HOLD_W | Trip hold setting for B, in ticks |
| guard_hold_b | input | HOLD_W | Guard hold setting for B, in ticks |
| trip_a | output | 1 | Command A trip output |
| guard_a | output | 1 | Command A guard output |
| ckbk_a | output | 1 | Command A checkback (trip request seen) |
| trip_b | output | 1 | Command B trip output |
| guard_b | output | 1 | Command B guard output |
| ckbk_b | output | 1 | Command B checkback (trip request seen) |

## Verification
The hardest situation to reach from the ports has the two channels in different lockout states at the same time. To get there, one channel has to sit in loss of channel long enough to lock, while the other receives its own trip tone the whole time. The bench gets there by unlocking both channels with guard and then holding only the command B tone for more than the trip-after-guard window. It then checks that A trips only as checkback and B still trips. It also sweeps the guard and loss durations one tick on each side of their limits, runs all sixteen tone combinations on unlocked channels, and sweeps the hold settings across and past their cap.

// File: rtl/tone_rx_pkg.sv
package tone_rx_pkg;

  // Effective hold length: a request above the cap is cut to the cap.
  function automatic int unsigned hold_limit(int unsigned req, int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

  // Next value of a consecutive-tick run counter that saturates at top-1.
  function automatic int unsigned run_step(int unsigned run, int unsigned top, logic present);
    if (!present) return 0;
    return (run + 1 >= top) ? top - 1 : run + 1;
  endfunction

endpackage

// File: rtl/rx_lock_supervisor.sv
module rx_lock_supervisor #(
  parameter int unsigned GBT_TICKS = 120,
  parameter int unsigned TAG_TICKS = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic guard_rx,
  input  logic loss_rx,
  output logic locked
);
  import tone_rx_pkg::*;

  localparam int unsigned GW = $clog2(GBT_TICKS + 1);
  localparam int unsigned LW = $clog2(TAG_TICKS + 1);

  logic [GW-1:0] guard_run;
  logic [LW-1:0] loss_run;
  logic          lock_q;

  // named events for the assertions
  logic gbt_done;
  logic tag_expire;
  assign gbt_done   = tick && guard_rx && (guard_run == GW'(GBT_TICKS - 1));
  assign tag_expire = tick && loss_rx  && (loss_run  == LW'(TAG_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      guard_run <= '0;
      loss_run  <= '0;
      lock_q    <= 1'b1;
    end else if (tick) begin
      guard_run <= GW'(run_step(32'(guard_run), GBT_TICKS, guard_rx));
      loss_run  <= LW'(run_step(32'(loss_run), TAG_TICKS, loss_rx));
      if (tag_expire)    lock_q <= 1'b1;
      else if (gbt_done) lock_q <= 1'b0;
    end
  end

  assign locked = lock_q;

  // R5: lockout only rises after a loss-of-channel tick
  assert_lock_after_loss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(loss_rx && tick));
  // R4: lockout only clears after a guard tick
  assert_unlock_after_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(guard_rx && tick));
  // R4: guard run never passes its window
  assert_guard_run_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    guard_run < GW'(GBT_TICKS));
  // R5: loss run never passes its window
  assert_loss_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loss_run < LW'(TAG_TICKS));
endmodule

// File: rtl/rx_hold_stretch.sv
module rx_hold_stretch #(
  parameter int unsigned HOLD_MAX = 100,
  parameter int unsigned HOLD_W   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  input  logic [HOLD_W-1:0] setting,
  output logic              out
);
  import tone_rx_pkg::*;

  localparam int unsigned CW = $clog2(HOLD_MAX + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)                    remain <= '0;
    else if (active)               remain <= CW'(hold_limit(32'(setting), HOLD_MAX));
    else if (tick && remain != '0) remain <= remain - 1'b1;
  end

  assign out = active | (remain != '0);

  // R10: stretch never longer than the cap
  assert_hold_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CW'(HOLD_MAX));
  // R8: stretch counts down one per tick once released
  assert_hold_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && tick && remain != '0) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/rx_cmd_channel.sv
module rx_cmd_channel #(
  parameter int unsigned GBT_TICKS = 120,
  parameter int unsigned TAG_TICKS = 120,
  parameter int unsigned HOLD_MAX  = 100,
  parameter int unsigned HOLD_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              guard_tone,
  input  logic              trip_req,
  input  logic [HOLD_W-1:0] trip_hold,
  input  logic [HOLD_W-1:0] guard_hold,
  output logic              trip_o,
  output logic              guard_o,
  output logic              ckbk_o
);
  logic guard_rx;
  logic loss_rx;
  logic locked;
  logic logic_trip;

  assign guard_rx   = guard_tone & ~trip_req;
  assign loss_rx    = ~guard_tone & ~trip_req;
  assign logic_trip = trip_req & ~locked;
  assign ckbk_o     = trip_req;

  rx_lock_supervisor #(.GBT_TICKS(GBT_TICKS), .TAG_TICKS(TAG_TICKS)) lock_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .guard_rx(guard_rx), .loss_rx(loss_rx), .locked(locked)
  );

  rx_hold_stretch #(.HOLD_MAX(HOLD_MAX), .HOLD_W(HOLD_W)) trip_hold_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .active(logic_trip), .setting(trip_hold), .out(trip_o)
  );

  rx_hold_stretch #(.HOLD_MAX(HOLD_MAX), .HOLD_W(HOLD_W)) guard_hold_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .active(guard_rx), .setting(guard_hold), .out(guard_o)
  );

  // R6: a trip output raised in this cycle always comes with a checkback
  assert_trip_has_ckbk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_o) |-> ckbk_o);
endmodule

// File: rtl/dual_cmd_tone_rx.sv
module dual_cmd_tone_rx #(
  parameter int unsigned GBT_TICKS = 120,
  parameter int unsigned TAG_TICKS = 120,
  parameter int unsigned HOLD_MAX  = 100,
  parameter int unsigned HOLD_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              tone_guard,
  input  logic              tone_cmd_a,
  input  logic              tone_cmd_b,
  input  logic              tone_both,
  input  logic [HOLD_W-1:0] trip_hold_a,
  input  logic [HOLD_W-1:0] guard_hold_a,
  input  logic [HOLD_W-1:0] trip_hold_b,
  input  logic [HOLD_W-1:0] guard_hold_b,
  output logic              trip_a,
  output logic              guard_a,
  output logic              ckbk_a,
  output logic              trip_b,
  output logic              guard_b,
  output logic              ckbk_b
);
  localparam int unsigned NCMD = 2;

  logic [NCMD-1:0]   req;
  logic [HOLD_W-1:0] t_hold [NCMD];
  logic [HOLD_W-1:0] g_hold [NCMD];
  logic [NCMD-1:0]   trip_v, guard_v, ckbk_v;

  // index 0 = command A, index 1 = command B; shared tone feeds both
  assign req[0]    = tone_cmd_a | tone_both;
  assign req[1]    = tone_cmd_b | tone_both;
  assign t_hold[0] = trip_hold_a;
  assign t_hold[1] = trip_hold_b;
  assign g_hold[0] = guard_hold_a;
  assign g_hold[1] = guard_hold_b;

  for (genvar c = 0; c < NCMD; c++) begin : g_cmd
    rx_cmd_channel #(
      .GBT_TICKS(GBT_TICKS), .TAG_TICKS(TAG_TICKS),
      .HOLD_MAX(HOLD_MAX), .HOLD_W(HOLD_W)
    ) chan_i (
      .clk(clk), .rst_n(rst_n), .tick(tick_ms),
      .guard_tone(tone_guard), .trip_req(req[c]),
      .trip_hold(t_hold[c]), .guard_hold(g_hold[c]),
      .trip_o(trip_v[c]), .guard_o(guard_v[c]), .ckbk_o(ckbk_v[c])
    );
  end

  assign trip_a  = trip_v[0];
  assign guard_a = guard_v[0];
  assign ckbk_a  = ckbk_v[0];
  assign trip_b  = trip_v[1];
  assign guard_b = guard_v[1];
  assign ckbk_b  = ckbk_v[1];

  // R1: the shared tone shows on both checkbacks
  assert_shared_tone_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tone_both |-> (ckbk_a && ckbk_b));
  // R2: a command A trip leaves command B guard standing
  assert_guard_b_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_guard && !tone_cmd_b && !tone_both) |-> guard_b);
  // R2: a command B trip leaves command A guard standing
  assert_guard_a_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_guard && !tone_cmd_a && !tone_both) |-> guard_a);
endmodule

// File: tb/dual_cmd_tone_rx_tb.sv
module dual_cmd_tone_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GBT = 6;
  localparam int TAG = 5;
  localparam int HMAX = 6;
  localparam int HW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tg = 0, ta = 0, tb = 0, tab = 0;
  logic [HW-1:0] th_a = 0, gh_a = 0, th_b = 0, gh_b = 0;
  logic trip_a, guard_a, ckbk_a, trip_b, guard_b, ckbk_b;
  int checks = 0;
  int errors = 0;
  bit wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_cmd_tone_rx #(.GBT_TICKS(GBT), .TAG_TICKS(TAG), .HOLD_MAX(HMAX), .HOLD_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick),
    .tone_guard(tg), .tone_cmd_a(ta), .tone_cmd_b(tb), .tone_both(tab),
    .trip_hold_a(th_a), .guard_hold_a(gh_a), .trip_hold_b(th_b), .guard_hold_b(gh_b),
    .trip_a(trip_a), .guard_a(guard_a), .ckbk_a(ckbk_a),
    .trip_b(trip_b), .guard_b(guard_b), .ckbk_b(ckbk_b)
  );

  task automatic chk(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic tones(logic g, logic a, logic b, logic ab);
    @(negedge clk);
    tg = g; ta = a; tb = b; tab = ab;
    #1;
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tg = 0; ta = 0; tb = 0; tab = 0; tick = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic unlock_both();
    tones(1, 0, 0, 0);
    run_ticks(GBT);
  endtask

  function automatic int eff(int s);
    return (s > HMAX) ? HMAX : s;
  endfunction

  initial begin
    fork
      begin : main_seq
        // R3: reset state
        @(negedge clk); #1;
        chk("R3 trip_a in reset", trip_a, 0);
        chk("R3 guard_b in reset", guard_b, 0);
        do_reset();
        chk("R3 trip_b idle", trip_b, 0);
        chk("R3 guard_a idle", guard_a, 0);
        tones(0, 0, 0, 1);
        chk("R3 locked trip_a", trip_a, 0);
        chk("R3 locked trip_b", trip_b, 0);
        chk("R3 ckbk_a", ckbk_a, 1);
        chk("R3 ckbk_b", ckbk_b, 1);

        // R4: guard-before-trip sweep across the window
        for (int n = 1; n <= GBT + 1; n++) begin
          do_reset();
          tones(1, 0, 0, 0);
          run_ticks(n);
          tones(1, 1, 0, 0);
          chk($sformatf("R4 trip_a after %0d guard ticks", n), trip_a, n >= GBT);
          chk("R6 ckbk_a with request", ckbk_a, 1);
        end
        // R4: interrupted guard restarts the count
        do_reset();
        tones(1, 0, 0, 0); run_ticks(GBT - 1);
        tones(0, 0, 0, 0); run_ticks(1);
        tones(1, 0, 0, 0); run_ticks(GBT - 1);
        tones(1, 1, 0, 0);
        chk("R4 interrupted guard still locked", trip_a, 0);
        tones(1, 0, 0, 0); run_ticks(1);
        tones(1, 1, 0, 0);
        chk("R4 guard run completed", trip_a, 1);

        // R5: trip-after-guard window sweep
        for (int m = 0; m <= TAG + 1; m++) begin
          do_reset();
          unlock_both();
          tones(0, 0, 0, 0);
          run_ticks(m);
          chk("R2 guard_a gone in loss", guard_a, 0);
          tones(0, 1, 0, 0);
          chk($sformatf("R5 trip_a after %0d loss ticks", m), trip_a, m < TAG);
        end

        // R1 R2 R6: all tone combinations on unlocked channels (no ticks)
        do_reset();
        unlock_both();
        for (int v = 0; v < 16; v++) begin
          logic g, a, b, ab, ra, rb;
          g = v[0]; a = v[1]; b = v[2]; ab = v[3];
          ra = a | ab; rb = b | ab;
          tones(g, a, b, ab);
          chk($sformatf("R1 trip_a combo %0d", v), trip_a, ra);
          chk($sformatf("R1 trip_b combo %0d", v), trip_b, rb);
          chk($sformatf("R1 ckbk_a combo %0d", v), ckbk_a, ra);
          chk($sformatf("R1 ckbk_b combo %0d", v), ckbk_b, rb);
          chk($sformatf("R2 guard_a combo %0d", v), guard_a, g & ~ra);
          chk($sformatf("R2 guard_b combo %0d", v), guard_b, g & ~rb);
        end

        // R7: A locks from loss while B trips continuously
        do_reset();
        unlock_both();
        tones(0, 0, 1, 0);
        run_ticks(TAG + 2);
        chk("R7 trip_b during A loss", trip_b, 1);
        tones(0, 1, 0, 0);
        chk("R7 A locked trip_a", trip_a, 0);
        chk("R6 A locked ckbk_a", ckbk_a, 1);
        tones(0, 0, 1, 0);
        chk("R7 B still unlocked", trip_b, 1);
        // R2: A trip with guard does not drop B guard nor lock B
        tones(1, 1, 0, 0);
        run_ticks(TAG + 2);
        chk("R2 guard_b kept under A trip", guard_b, 1);
        chk("R2 trip_b idle under A trip", trip_b, 0);
        tones(1, 0, 1, 0);
        chk("R7 B trips after A activity", trip_b, 1);

        // R8 R10: trip hold sweep including clamp
        for (int h = 0; h <= HMAX + 3; h++) begin
          int e;
          e = eff(h);
          do_reset();
          th_a = HW'(h);
          unlock_both();
          tones(1, 1, 0, 0);
          run_ticks(1);
          tones(1, 0, 0, 0);
          chk($sformatf("R8 trip_a hold %0d at release", h), trip_a, e > 0);
          for (int k = 1; k <= e + 1; k++) begin
            run_ticks(1);
            chk($sformatf("R10 R8 trip_a hold %0d after %0d ticks", h, k), trip_a, k < e);
          end
        end
        th_a = 0;

        // R9 R10: guard hold sweep on channel B
        for (int g = 0; g <= HMAX + 2; g++) begin
          int e;
          e = eff(g);
          do_reset();
          gh_b = HW'(g);
          unlock_both();
          tones(1, 0, 1, 0);
          chk($sformatf("R9 guard_b hold %0d at release", g), guard_b, e > 0);
          chk("R2 guard_a kept under B trip", guard_a, 1);
          for (int k = 1; k <= e + 1; k++) begin
            run_ticks(1);
            chk($sformatf("R10 R9 guard_b hold %0d after %0d ticks", g, k), guard_b, k < e);
          end
        end
        gh_b = 0;
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_any
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule